// File: doc/BRIEF.md
# Mode-Dependent Odd Parity Checker/Generator

This block sits between a parallel user interface and a line encoder/decoder pair. On the transmit side it checks that the user data byte, optionally with its two control bits, and the supplied parity bit together carry odd parity. It raises a registered error flag one clock after a bad word. On the receive side it registers the decoded byte and status bits and produces an odd parity bit that stays aligned with them. It also produces an enable for that bit, so that a pad driver can float it.

A two-bit level input selects off, mid or high coverage. At mid, the encoder and decoder enable inputs widen or narrow the covered fields. The transmit check follows the encoder enable and the receive generation follows the decoder enable. At high, coverage is at its widest whatever the enables are. Encoding, decoding and status generation are outside this block; their data arrives on plain inputs.

Top module: `odd_parity_unit`

## Requirements
- R1: With par_level 2'b00 (off) or 2'b11 (treated as off), tx_par_err is 0, rx_par is 0 and rx_par_oe is 0 one clock after the inputs are applied.
- R2: With par_level 2'b01 (mid) and enc_on=1, tx_par_err one clock later is 1 exactly when {tx_data, tx_par} has an even number of ones; tx_ctl has no effect.
- R3: With par_level 2'b01 and enc_on=0, tx_par_err one clock later is 1 exactly when {tx_data, tx_ctl, tx_par} has an even number of ones.
- R4: With par_level 2'b10 (high), tx_par_err one clock later is 1 exactly when {tx_data, tx_ctl, tx_par} has an even number of ones, for either value of enc_on.
- R5: With par_level 2'b01 and dec_on=1, rx_par one clock later makes {rx_data, rx_par} contain an odd number of ones; rx_sts has no effect on it.
- R6: With par_level 2'b01 and dec_on=0, rx_par one clock later makes {rx_data, rx_sts[1:0], rx_par} odd; rx_sts[2] has no effect on it.
- R7: With par_level 2'b10, rx_par one clock later makes {rx_data, rx_sts[2:0], rx_par} odd, for either value of dec_on.
- R8: rx_data_q and rx_sts_q equal rx_data and rx_sts from one clock earlier, in the same cycle as the rx_par computed from them.
- R9: While rst is high at a clock edge, every output is 0 after that edge.
- R10: With par_level 2'b01 or 2'b10, rx_par_oe is 1 one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_level | input | 2 | Coverage level: 00 off, 01 mid, 10 high, 11 off |
| enc_on | input | 1 | Encoder enabled (0 = bypassed) |
| dec_on | input | 1 | Decoder enabled (0 = bypassed) |
| tx_data | input | 8 | Transmit data byte |
| tx_ctl | input | 2 | Transmit control bits |
| tx_par | input | 1 | Transmit parity bit supplied by the user |
| rx_data | input | 8 | Receive data byte from the decoder |
| rx_sts | input | 3 | Receive status bits |
| tx_par_err | output | 1 | Registered transmit parity error |
| rx_data_q | output | 8 | Registered receive data |
| rx_sts_q | output | 3 | Registered receive status |
| rx_par | output | 1 | Registered odd parity over the covered receive fields |
| rx_par_oe | output | 1 | Output enable for rx_par |

## Verification
The hardest cases show up only in a few level and enable combinations. One is the mid level with one side bypassed and the other not. Others are the reserved level code, and the status bit that mid leaves out while high covers it. A mismatch there changes rx_par or tx_par_err only for certain data. The stimulus sweeps all four level codes, every enable pair, every transmit byte, control pair and parity bit, and a receive word derived from them. Each combination therefore occurs with both parity outcomes, and the bench checks that the excluded bits have no effect.

// File: rtl/opar_pkg.sv
package opar_pkg;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_RSV  = 2'b11
  } lvl_e;

  typedef struct packed {
    logic active;      // parity function on
    logic tx_ctl_cov;  // transmit control bits covered
    logic rx_sts_part; // lower receive status bits covered
    logic rx_sts_all;  // every receive status bit covered
  } cover_t;

endpackage

// File: rtl/opar_mode_dec.sv
module opar_mode_dec
  import opar_pkg::*;
(
  input  logic [1:0] par_level,
  input  logic       enc_on,
  input  logic       dec_on,
  output cover_t     cov
);

  lvl_e lvl;

  always_comb begin
    lvl = lvl_e'(par_level);
    cov = '0;
    unique case (lvl)
      LVL_MID: begin
        cov.active      = 1'b1;
        cov.tx_ctl_cov  = ~enc_on;
        cov.rx_sts_part = ~dec_on;
        cov.rx_sts_all  = 1'b0;
      end
      LVL_HIGH: begin
        cov.active      = 1'b1;
        cov.tx_ctl_cov  = 1'b1;
        cov.rx_sts_part = 1'b1;
        cov.rx_sts_all  = 1'b1;
      end
      default: cov = '0;
    endcase
  end

endmodule

// File: rtl/opar_tx_check.sv
module opar_tx_check
  import opar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cover_t            cov,
  input  logic [DATA_W-1:0] data,
  input  logic [CTL_W-1:0]  ctl,
  input  logic              par,
  output logic              err
);

  logic [CTL_W-1:0] ctl_m;
  logic             ones_odd;

  always_comb begin
    ctl_m    = cov.tx_ctl_cov ? ctl : '0;
    ones_odd = ^{data, ctl_m, par};
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= cov.active & ~ones_odd;
  end

endmodule

// File: rtl/opar_rx_gen.sv
module opar_rx_gen
  import opar_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STS_W     = 3,
  parameter int STS_MID_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cover_t            cov,
  input  logic [DATA_W-1:0] data,
  input  logic [STS_W-1:0]  sts,
  output logic [DATA_W-1:0] data_q,
  output logic [STS_W-1:0]  sts_q,
  output logic              par_q,
  output logic              oe_q
);

  logic [STS_W-1:0] sts_mask;
  logic             par_d;

  for (genvar i = 0; i < STS_W; i++) begin : g_mask
    if (i < STS_MID_W) begin : g_part
      assign sts_mask[i] = cov.rx_sts_part | cov.rx_sts_all;
    end else begin : g_full
      assign sts_mask[i] = cov.rx_sts_all;
    end
  end

  always_comb begin
    par_d = cov.active & ~(^{data, sts & sts_mask});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      sts_q  <= '0;
      par_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= data;
      sts_q  <= sts;
      par_q  <= par_d;
      oe_q   <= cov.active;
    end
  end

endmodule

// File: rtl/odd_parity_unit.sv
module odd_parity_unit
  import opar_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CTL_W     = 2,
  parameter int STS_W     = 3,
  parameter int STS_MID_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        par_level,
  input  logic              enc_on,
  input  logic              dec_on,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [CTL_W-1:0]  tx_ctl,
  input  logic              tx_par,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [STS_W-1:0]  rx_sts,
  output logic              tx_par_err,
  output logic [DATA_W-1:0] rx_data_q,
  output logic [STS_W-1:0]  rx_sts_q,
  output logic              rx_par,
  output logic              rx_par_oe
);

  cover_t cov;

  opar_mode_dec u_dec (
    .par_level (par_level),
    .enc_on    (enc_on),
    .dec_on    (dec_on),
    .cov       (cov)
  );

  opar_tx_check #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_tx (
    .clk  (clk),
    .rst  (rst),
    .cov  (cov),
    .data (tx_data),
    .ctl  (tx_ctl),
    .par  (tx_par),
    .err  (tx_par_err)
  );

  opar_rx_gen #(.DATA_W(DATA_W), .STS_W(STS_W), .STS_MID_W(STS_MID_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .cov    (cov),
    .data   (rx_data),
    .sts    (rx_sts),
    .data_q (rx_data_q),
    .sts_q  (rx_sts_q),
    .par_q  (rx_par),
    .oe_q   (rx_par_oe)
  );

endmodule

// File: rtl/opar_chk.sv
module opar_chk #(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 2,
  parameter int STS_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        par_level,
  input logic              enc_on,
  input logic              dec_on,
  input logic [DATA_W-1:0] tx_data,
  input logic [CTL_W-1:0]  tx_ctl,
  input logic              tx_par,
  input logic [DATA_W-1:0] rx_data,
  input logic [STS_W-1:0]  rx_sts,
  input logic              tx_par_err,
  input logic [DATA_W-1:0] rx_data_q,
  input logic [STS_W-1:0]  rx_sts_q,
  input logic              rx_par,
  input logic              rx_par_oe
);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (par_level == 2'b00 || par_level == 2'b11) |=> (!tx_par_err && !rx_par_oe && !rx_par)); // R1
  AST_TX_HIGH: assert property (@(posedge clk) disable iff (rst)
    (par_level == 2'b10) |=> (tx_par_err == ~(^{$past(tx_data), $past(tx_ctl), $past(tx_par)}))); // R4
  AST_RX_MID_DEC: assert property (@(posedge clk) disable iff (rst)
    (par_level == 2'b01 && dec_on) |=> (^{rx_data_q, rx_par})); // R5
  AST_RX_HIGH: assert property (@(posedge clk) disable iff (rst)
    (par_level == 2'b10) |=> (^{rx_data_q, rx_sts_q, rx_par})); // R7
  AST_RX_ALIGN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rx_data_q == $past(rx_data) && rx_sts_q == $past(rx_sts))); // R8
  AST_OE_ON: assert property (@(posedge clk) disable iff (rst)
    (par_level == 2'b01 || par_level == 2'b10) |=> rx_par_oe); // R10

endmodule

bind odd_parity_unit opar_chk #(.DATA_W(DATA_W), .CTL_W(CTL_W), .STS_W(STS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .par_level  (par_level),
  .enc_on     (enc_on),
  .dec_on     (dec_on),
  .tx_data    (tx_data),
  .tx_ctl     (tx_ctl),
  .tx_par     (tx_par),
  .rx_data    (rx_data),
  .rx_sts     (rx_sts),
  .tx_par_err (tx_par_err),
  .rx_data_q  (rx_data_q),
  .rx_sts_q   (rx_sts_q),
  .rx_par     (rx_par),
  .rx_par_oe  (rx_par_oe)
);

// File: tb/odd_parity_unit_test.sv
module odd_parity_unit_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] par_level;
  logic       enc_on, dec_on;
  logic [7:0] tx_data, rx_data;
  logic [1:0] tx_ctl;
  logic       tx_par;
  logic [2:0] rx_sts;
  logic       tx_par_err, rx_par, rx_par_oe;
  logic [7:0] rx_data_q;
  logic [2:0] rx_sts_q;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  odd_parity_unit uut (
    .clk(clk), .rst(rst), .par_level(par_level), .enc_on(enc_on), .dec_on(dec_on),
    .tx_data(tx_data), .tx_ctl(tx_ctl), .tx_par(tx_par), .rx_data(rx_data), .rx_sts(rx_sts),
    .tx_par_err(tx_par_err), .rx_data_q(rx_data_q), .rx_sts_q(rx_sts_q),
    .rx_par(rx_par), .rx_par_oe(rx_par_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d lvl=%0d enc=%0d dec=%0d txd=%h ctl=%0d p=%0d",
               tag, act, exp, par_level, enc_on, dec_on, tx_data, tx_ctl, tx_par);
    end
  endtask

  task automatic step_and_check;
    bit on, exp_err, exp_par;
    string ttag, rtag;
    on = (par_level == 2'b01) || (par_level == 2'b10);
    if (!on) begin
      exp_err = 1'b0; exp_par = 1'b0; ttag = "R1"; rtag = "R1";
    end else begin
      if (par_level == 2'b10) begin
        exp_err = ~(^{tx_data, tx_ctl, tx_par}); ttag = "R4";
        exp_par = ~(^{rx_data, rx_sts}); rtag = "R7";
      end else begin
        if (enc_on) begin exp_err = ~(^{tx_data, tx_par}); ttag = "R2"; end
        else begin exp_err = ~(^{tx_data, tx_ctl, tx_par}); ttag = "R3"; end
        if (dec_on) begin exp_par = ~(^rx_data); rtag = "R5"; end
        else begin exp_par = ~(^{rx_data, rx_sts[1:0]}); rtag = "R6"; end
      end
    end
    @(posedge clk);
    #2;
    check({ttag, " tx_par_err"}, tx_par_err, exp_err);
    check({rtag, " rx_par"}, rx_par, exp_par);
    check(on ? "R10 rx_par_oe" : "R1 rx_par_oe", rx_par_oe, on);
    check("R8 rx_data_q", rx_data_q, rx_data);
    check("R8 rx_sts_q", rx_sts_q, rx_sts);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; par_level = 2'b10; enc_on = 1'b0; dec_on = 1'b0;
    tx_data = 8'h00; tx_ctl = 2'b00; tx_par = 1'b0;
    rx_data = 8'hFF; rx_sts = 3'b111;
    repeat (3) @(posedge clk);
    #2;
    check("R9 tx_par_err", tx_par_err, 0);
    check("R9 rx_par", rx_par, 0);
    check("R9 rx_par_oe", rx_par_oe, 0);
    check("R9 rx_data_q", rx_data_q, 0);
    check("R9 rx_sts_q", rx_sts_q, 0);
    @(negedge clk);
    rst = 1'b0;
    for (int lv = 0; lv < 4; lv++) begin
      for (int ed = 0; ed < 4; ed++) begin
        for (int d = 0; d < 256; d++) begin
          for (int cp = 0; cp < 8; cp++) begin
            par_level = 2'(lv);
            enc_on    = ed[0];
            dec_on    = ed[1];
            tx_data   = 8'(d);
            tx_ctl    = 2'(cp >> 1);
            tx_par    = cp[0];
            rx_data   = 8'(d) ^ 8'h5A;
            rx_sts    = 3'(cp ^ (d & 7));
            step_and_check();
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule